// File: doc/BRIEF.md
# Processor condition and enable register

This block holds the processor-level condition flags, the per-condition interrupt enables and the interrupt channel assignment. One write word can do several things at once. It always loads a new channel number. It also picks a group of conditions with a field mask. Four independent action bits then decide whether those conditions are enabled, disabled, cleared or set. A read command returns enables, flags and channel repacked into a single word on the following cycle.

A dedicated timer input sets the timer condition flag when its countdown expires. The block raises a one-hot interrupt request on the assigned channel whenever an enabled condition flag is set. One condition bit is a notification to a service processor: it is never stored. Loading it produces a single-cycle pulse instead.

Top module: `proc_cond_reg`

## Requirements
- R1: After reset the enables, flags and channel are zero, `irq_req` is zero, and `rd_valid` and `svc_notify` are low.
- R2: Every write replaces the stored channel with `wr_data[2:0]`.
- R3: The condition field is `wr_data & 'o007760` (bits 4..11); write data bits outside this field never reach the enables or flags. Bit 15 ORs the field into the enables and bit 14 clears those enables. When both bits are set, clearing wins.
- R4: Bit 13 clears the selected flags and bit 12 sets them. Clearing is applied first, so when both are set the selected flags end up set.
- R5: A write with neither bit 13 nor bit 12 leaves every flag unchanged.
- R6: Flag bit 10 is forced to zero whenever flags are loaded. If the loaded value had bit 10 set, `svc_notify` is high for exactly the following cycle.
- R7: `timer_expire` sets flag bit 5 (octal 040) on the next edge. This set takes effect even if a write in the same cycle clears that flag.
- R8: A read asserts `rd_valid` one cycle later with `rd_data` made up as follows: enables in bits 22..29 (the enable field shifted into the left 18-bit half), `flags & 'o007770` in the right half, and the channel in bits 0..2. A read in the same cycle as a write returns the state from before that write.
- R9: `irq_req` is one-hot at index channel when `(flags & enables & 'o007760)` is nonzero and the channel is nonzero. It is all zero otherwise; channel 0 never requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write command strobe |
| wr_data | input | 36 | Write word: channel, condition field, action bits |
| rd_en | input | 1 | Read command strobe |
| timer_expire | input | 1 | Timer countdown expired, sets flag bit 5 |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 36 | Packed enables, flags and channel |
| irq_req | output | 8 | One-hot interrupt request by channel |
| svc_notify | output | 1 | Single-cycle service-processor notification |

## Verification
On every cycle, the assertions check the following: channel loading, enables holding when no write arrives, flags holding on writes that carry no flag action, flag bits staying inside the condition field, the service bit never being stored, the timer flag landing, read latency, and the one-hot shape of the request. The order of operations is something only the bench scenarios can show. This covers clear-before-set on flags, disable beating enable, the timer beating a same-cycle clear, and a read racing a write. The exact packed read word and the request index also need those scenarios, which compare against a reference model.

// File: rtl/pcer_pkg.sv
package pcer_pkg;
    parameter int HALF_W = 18;
    parameter int WORD_W = 2 * HALF_W;
    parameter int CHAN_W = 3;
    parameter int NCHAN  = 1 << CHAN_W;

    localparam logic [HALF_W-1:0] COND_MASK    = HALF_W'(18'o007760);
    localparam logic [HALF_W-1:0] RD_FLAG_MASK = HALF_W'(18'o007770);

    localparam int BIT_EN_SET = 15;
    localparam int BIT_EN_CLR = 14;
    localparam int BIT_FL_CLR = 13;
    localparam int BIT_FL_SET = 12;
    localparam int BIT_SVC    = 10;
    localparam int BIT_TIMER  = 5;

    typedef struct packed {
        logic [HALF_W-1:0] en;
        logic [HALF_W-1:0] fl;
        logic [CHAN_W-1:0] ch;
        logic              svc;
        logic              rd_valid;
        logic [WORD_W-1:0] rd_data;
    } pcer_state_t;
endpackage

// File: rtl/pcer_wr_decode.sv
module pcer_wr_decode
    import pcer_pkg::*;
(
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_half,
    input  logic              timer_expire,
    input  logic [HALF_W-1:0] en_cur,
    input  logic [HALF_W-1:0] fl_cur,
    input  logic [CHAN_W-1:0] ch_cur,
    output logic [HALF_W-1:0] en_nxt,
    output logic [HALF_W-1:0] fl_nxt,
    output logic [CHAN_W-1:0] ch_nxt,
    output logic              svc_nxt
);
    logic [HALF_W-1:0] field;
    logic [HALF_W-1:0] fl_load;
    logic              fl_touch;

    always_comb begin
        field    = wr_half & COND_MASK;
        fl_touch = wr_en && (wr_half[BIT_FL_CLR] || wr_half[BIT_FL_SET]);

        en_nxt = en_cur;
        ch_nxt = ch_cur;
        if (wr_en) begin
            ch_nxt = wr_half[CHAN_W-1:0];
            if (wr_half[BIT_EN_SET]) en_nxt = en_nxt | field;
            if (wr_half[BIT_EN_CLR]) en_nxt = en_nxt & ~field;
        end

        fl_load = fl_cur;
        if (wr_half[BIT_FL_CLR]) fl_load = fl_load & ~field;
        if (wr_half[BIT_FL_SET]) fl_load = fl_load | field;

        svc_nxt = fl_touch && fl_load[BIT_SVC];
        fl_nxt  = fl_cur;
        if (fl_touch) begin
            fl_nxt          = fl_load;
            fl_nxt[BIT_SVC] = 1'b0;
        end
        if (timer_expire) fl_nxt[BIT_TIMER] = 1'b1;
    end
endmodule

// File: rtl/pcer_irq_enc.sv
module pcer_irq_enc
    import pcer_pkg::*;
(
    input  logic [HALF_W-1:0] en,
    input  logic [HALF_W-1:0] fl,
    input  logic [CHAN_W-1:0] ch,
    output logic [NCHAN-1:0]  irq_req
);
    logic pending;

    always_comb begin
        pending = |(en & fl & COND_MASK);
    end

    for (genvar i = 0; i < NCHAN; i++) begin : g_chan
        if (i == 0) begin : g_none
            assign irq_req[i] = 1'b0;
        end else begin : g_line
            assign irq_req[i] = pending && (ch == CHAN_W'(i));
        end
    end
endmodule

// File: rtl/pcer_pack.sv
module pcer_pack
    import pcer_pkg::*;
(
    input  logic [HALF_W-1:0] en,
    input  logic [HALF_W-1:0] fl,
    input  logic [CHAN_W-1:0] ch,
    output logic [WORD_W-1:0] word
);
    logic [HALF_W-1:0] left_h;
    logic [HALF_W-1:0] right_h;

    always_comb begin
        left_h  = en & COND_MASK;
        right_h = (fl & RD_FLAG_MASK) | HALF_W'(ch);
        word    = {left_h, right_h};
    end
endmodule

// File: rtl/proc_cond_reg.sv
module proc_cond_reg
    import pcer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              timer_expire,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [NCHAN-1:0]  irq_req,
    output logic              svc_notify
);
    pcer_state_t s_d, s_q;

    logic [HALF_W-1:0] en_n, fl_n;
    logic [CHAN_W-1:0] ch_n;
    logic              svc_n;
    logic [WORD_W-1:0] packed_w;

    pcer_wr_decode u_dec (
        .wr_en        (wr_en),
        .wr_half      (wr_data[HALF_W-1:0]),
        .timer_expire (timer_expire),
        .en_cur       (s_q.en),
        .fl_cur       (s_q.fl),
        .ch_cur       (s_q.ch),
        .en_nxt       (en_n),
        .fl_nxt       (fl_n),
        .ch_nxt       (ch_n),
        .svc_nxt      (svc_n)
    );

    pcer_pack u_pack (
        .en   (s_q.en),
        .fl   (s_q.fl),
        .ch   (s_q.ch),
        .word (packed_w)
    );

    pcer_irq_enc u_irq (
        .en      (s_q.en),
        .fl      (s_q.fl),
        .ch      (s_q.ch),
        .irq_req (irq_req)
    );

    always_comb begin
        s_d          = s_q;
        s_d.en       = en_n;
        s_d.fl       = fl_n;
        s_d.ch       = ch_n;
        s_d.svc      = svc_n;
        s_d.rd_valid = rd_en;
        if (rd_en) s_d.rd_data = packed_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid   = s_q.rd_valid;
    assign rd_data    = s_q.rd_data;
    assign svc_notify = s_q.svc;

    // R2: a write always loads the channel
    assert_chan_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (s_q.ch == $past(wr_data[CHAN_W-1:0])));

    // R3: enables only move on a write
    assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q.en));

    // R4: flags never leave the condition field
    assert_flag_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fl & ~COND_MASK) == '0);

    // R5: a write without flag action keeps the flags
    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[BIT_FL_CLR] && !wr_data[BIT_FL_SET] && !timer_expire)
        |=> $stable(s_q.fl));

    // R6: the service bit is never held
    assert_svc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.fl[BIT_SVC]);

    // R7: timer expiry lands in its flag
    assert_timer_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_expire |=> s_q.fl[BIT_TIMER]);

    // R8: read data valid exactly one cycle after a read
    assert_read_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_read_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R9: at most one request line, never on channel 0
    assert_irq_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_req) && !irq_req[0]);
endmodule

// File: tb/tb_proc_cond_reg.sv
module tb_proc_cond_reg;
    localparam int HW = 18;
    localparam int WW = 36;
    localparam logic [HW-1:0] FIELD  = 18'o007760;
    localparam logic [HW-1:0] RDMASK = 18'o007770;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [WW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          timer_expire = 1'b0;
    logic          rd_valid;
    logic [WW-1:0] rd_data;
    logic [7:0]    irq_req;
    logic          svc_notify;

    int checks = 0;
    int errors = 0;

    logic [HW-1:0] m_en = '0, m_fl = '0;
    logic [2:0]    m_ch = '0;
    logic          m_svc = 1'b0, m_rv = 1'b0;
    logic [WW-1:0] m_rd = '0;

    always #10 clk = ~clk;

    proc_cond_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .timer_expire(timer_expire), .rd_valid(rd_valid),
        .rd_data(rd_data), .irq_req(irq_req), .svc_notify(svc_notify)
    );

    function automatic logic [WW-1:0] f_pack(logic [HW-1:0] e, logic [HW-1:0] f, logic [2:0] c);
        return {e & FIELD, (f & RDMASK) | HW'(c)};
    endfunction

    function automatic logic [7:0] f_irq(logic [HW-1:0] e, logic [HW-1:0] f, logic [2:0] c);
        if (c != 3'd0 && |(e & f & FIELD)) return 8'(1) << c;
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic we, input logic [WW-1:0] wd, input logic re, input logic tm);
        logic [HW-1:0] fld, t;
        logic touch;
        fld = wd[HW-1:0] & FIELD;
        m_rv = re;
        if (re) m_rd = f_pack(m_en, m_fl, m_ch);
        touch = we && (wd[13] || wd[12]);
        m_svc = 1'b0;
        if (we) begin
            m_ch = wd[2:0];
            if (wd[15]) m_en = m_en | fld;
            if (wd[14]) m_en = m_en & ~fld;
        end
        if (touch) begin
            t = m_fl;
            if (wd[13]) t = t & ~fld;
            if (wd[12]) t = t | fld;
            m_svc = t[10];
            t[10] = 1'b0;
            m_fl = t;
        end
        if (tm) m_fl[5] = 1'b1;
    endtask

    task automatic cyc(input logic we, input logic [WW-1:0] wd, input logic re,
                       input logic tm, input string tag);
        @(negedge clk);
        wr_en = we; wr_data = wd; rd_en = re; timer_expire = tm;
        @(posedge clk);
        model_step(we, wd, re, tm);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; timer_expire = 1'b0;
        chk({tag, " R8 rd_valid"}, WW'(rd_valid), WW'(m_rv));
        if (m_rv) chk({tag, " R8 rd_data"}, rd_data, m_rd);
        chk({tag, " R9 irq_req"}, WW'(irq_req), WW'(f_irq(m_en, m_fl, m_ch)));
        chk({tag, " R6 svc_notify"}, WW'(svc_notify), WW'(m_svc));
    endtask

    initial begin
        #5_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [WW-1:0] w;
        seed = 32'd2024;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq_req", WW'(irq_req), '0);
        chk("R1 rd_valid", WW'(rd_valid), '0);
        chk("R1 svc_notify", WW'(svc_notify), '0);
        cyc(0, '0, 1, 0, "R1 read");
        chk("R1 packed zero", rd_data, '0);

        // R2 R3: enable field and channel 3; junk bits outside the field
        cyc(1, 36'o777000_100000 | 36'o007760 | 36'o3, 0, 0, "R2 R3 enable");
        cyc(0, '0, 1, 0, "R3 read");
        chk("R3 enables packed", rd_data, (36'o7760 << 18) | 36'o3);

        // R4: set timer-bit flag, request on channel 3
        cyc(1, 36'o010040 | 36'o3, 0, 0, "R4 set");
        chk("R9 chan3", WW'(irq_req), WW'(8'b0000_1000));

        // R6: service bit notifies and is dropped
        cyc(1, 36'o010000 | 36'o002100 | 36'o5, 0, 0, "R6 svc");
        chk("R6 pulse", WW'(svc_notify), 1);
        cyc(0, '0, 1, 0, "R6 read");
        chk("R6 bit10 clear", rd_data, (36'o7760 << 18) | 36'o140 | 36'o5);
        chk("R6 pulse one cycle", WW'(svc_notify), 0);

        // R4: clear and set together -> set wins
        cyc(1, 36'o030140 | 36'o5, 1, 0, "R4 both");
        cyc(0, '0, 1, 0, "R4 read");
        chk("R4 set wins", rd_data[HW-1:0], 18'o145);

        // R9: channel 0 never requests
        cyc(1, 36'o020040, 0, 0, "R9 chan0");
        chk("R9 chan0 idle", WW'(irq_req), 0);

        // R5: no flag action keeps flags
        cyc(1, 36'o007762, 1, 0, "R5 hold");
        cyc(0, '0, 1, 0, "R5 read");
        chk("R5 flags kept", rd_data[HW-1:0], 18'o102);

        // R7: timer beats a same-cycle clear
        cyc(1, 36'o020040 | 36'o2, 0, 1, "R7 timer");
        cyc(0, '0, 1, 0, "R7 read");
        chk("R7 timer flag", rd_data[HW-1:0], 18'o142);

        // R3: enable and disable together -> disabled
        cyc(1, 36'o147760 | 36'o2, 0, 0, "R3 both");
        chk("R9 no enables", WW'(irq_req), 0);
        // R8: read races write, returns old state
        cyc(1, 36'o107760 | 36'o7, 1, 0, "R8 race");
        chk("R8 old state", rd_data, f_pack('0, 18'o140, 3'd2));

        // random mix
        for (int i = 0; i < 400; i++) begin
            w = {$urandom(), $urandom()};
            w[2:0] = 3'($urandom_range(0, 7));
            cyc(($urandom_range(0, 3) != 0), w, ($urandom_range(0, 1) != 0),
                ($urandom_range(0, 7) == 0), "R2 R4 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule